// File: doc/BRIEF.md
# Sixteen-Bit Integer ALU with Zero and Exception Flags

This block is the arithmetic and logic stage of a small 16-bit processor datapath. It is purely combinational. An instruction decoder supplies a 3-bit operation selector and two operands. The block returns a result word and two condition flags within the same cycle. A status register downstream captures them.

The block has eight operations:

- a no-operation
- signed add and subtract
- signed multiply
- three bitwise logic operations
- a pass-through of the second operand

The zero flag reports a zero result. The exception flag reports that a signed value did not fit in the result width. Both flags depend only on the operation now applied, so no flag outlives the operation that raised it. A bound checker watches the inputs for unknown values in simulation.

Top module: `alu16`

## Requirements
- R1: The selector encodings are 000 no-op, 001 add, 010 subtract, 011 multiply, 100 AND, 101 OR, 110 XOR and 111 pass. For the no-op, the result is all zeros, the zero flag is 1 and the exception flag is 0.
- R2: For add (001), the result is the low 16 bits of a+b. The exception flag is 1 exactly when the signed sum lies outside -32768..32767.
- R3: For subtract (010), the result is the low 16 bits of a-b. The exception flag is 1 exactly when the signed difference lies outside -32768..32767.
- R4: For multiply (011), the operands are signed and the result is the low 16 bits of the 32-bit product. The exception flag is 1 exactly when the product lies outside -32768..32767.
- R5: For AND (100), OR (101) and XOR (110), the result is the bitwise combination of a and b, and the exception flag is 0.
- R6: For pass (111), the result equals b unchanged, and the exception flag is 0.
- R7: For every selector value, the zero flag is 1 exactly when all 16 result bits are 0.
- R8: The flags hold no state. When an operation that sets a flag is followed by one that does not set it, that flag reads 0 as soon as the new inputs settle.
- R9: The operands and the selector are never unknown while the block is in use. A simulation-only check reports any X or Z on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation selector (encoding in R1) |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand; the value forwarded by pass |
| res_o | output | 16 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| exc_o | output | 1 | Signed result did not fit in 16 bits |

## Verification
The checker assumes that the operands and the selector carry only known 0/1 values, and that the outputs are sampled only after the inputs have settled. The bench gives every input an initial value before time zero. It changes inputs only on the falling clock edge and reads the outputs a few nanoseconds later. Random stimulus always draws full 16-bit and 3-bit values, so every selector code is a legal operation. Directed cases exercise the overflow boundaries, including the most negative operand. They also exercise a flag-raising operation followed at once by one that does not raise the flag.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 3'b000,
        OP_ADD  = 3'b001,
        OP_SUB  = 3'b010,
        OP_MUL  = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_PASS = 3'b111
    } alu_op_e;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         sum_ovf_o,
    output logic [W-1:0] diff_o,
    output logic         diff_ovf_o,
    output logic [W-1:0] prod_o,
    output logic         prod_ovf_o
);
    localparam int PW = 2 * W;

    logic [W:0]            sum_ext;
    logic [W:0]            diff_ext;
    logic signed [PW-1:0]  prod_full;
    logic [W:0]            prod_top;

    always_comb begin
        sum_ext    = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        diff_ext   = {a_i[W-1], a_i} - {b_i[W-1], b_i};
        prod_full  = PW'($signed(a_i)) * PW'($signed(b_i));
        prod_top   = prod_full[PW-1:W-1];
        sum_o      = sum_ext[W-1:0];
        sum_ovf_o  = sum_ext[W] ^ sum_ext[W-1];
        diff_o     = diff_ext[W-1:0];
        diff_ovf_o = diff_ext[W] ^ diff_ext[W-1];
        prod_o     = prod_full[W-1:0];
        prod_ovf_o = !((&prod_top) || (~|prod_top));
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign and_o[i] = a_i[i] & b_i[i];
            assign or_o[i]  = a_i[i] | b_i[i];
            assign xor_o[i] = a_i[i] ^ b_i[i];
        end
    endgenerate
endmodule

// File: rtl/alu16.sv
module alu16
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    res_o,
    output logic            zero_o,
    output logic            exc_o
);
    logic [W-1:0] sum, diff, prod, land, lor, lxor;
    logic         sum_ovf, diff_ovf, prod_ovf;
    alu_op_e      op;

    alu16_arith #(.W(W)) u_arith (
        .a_i(a_i), .b_i(b_i),
        .sum_o(sum),   .sum_ovf_o(sum_ovf),
        .diff_o(diff), .diff_ovf_o(diff_ovf),
        .prod_o(prod), .prod_ovf_o(prod_ovf)
    );

    alu16_logic #(.W(W)) u_logic (
        .a_i(a_i), .b_i(b_i),
        .and_o(land), .or_o(lor), .xor_o(lxor)
    );

    assign op = alu_op_e'(op_i);

    always_comb begin
        res_o = '0;
        exc_o = 1'b0;
        unique case (op)
            OP_NOP:  begin res_o = '0;   exc_o = 1'b0;     end
            OP_ADD:  begin res_o = sum;  exc_o = sum_ovf;  end
            OP_SUB:  begin res_o = diff; exc_o = diff_ovf; end
            OP_MUL:  begin res_o = prod; exc_o = prod_ovf; end
            OP_AND:  begin res_o = land; exc_o = 1'b0;     end
            OP_OR:   begin res_o = lor;  exc_o = 1'b0;     end
            OP_XOR:  begin res_o = lxor; exc_o = 1'b0;     end
            OP_PASS: begin res_o = b_i;  exc_o = 1'b0;     end
        endcase
        zero_o = ~|res_o;
    end
endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
    parameter int W = 16
) (
    input logic [2:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] res_o,
    input logic         zero_o,
    input logic         exc_o
);
    always_comb begin
        a_r9_no_unknown: assert (!$isunknown({op_i, a_i, b_i}))
            else $error("R9: unknown value on ALU inputs");
        a_r7_zero_flag: assert (zero_o == (res_o == '0))
            else $error("R7: zero flag disagrees with result");
        if (op_i == 3'b000) begin
            a_r1_noop_zero: assert (res_o == '0 && zero_o && !exc_o)
                else $error("R1: no-op result not zero");
        end
        if (op_i == 3'b001) begin
            a_r2_add_overflow: assert (exc_o == ((a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1])))
                else $error("R2: add overflow flag wrong");
        end
        if (op_i == 3'b010) begin
            a_r3_sub_overflow: assert (exc_o == ((a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1])))
                else $error("R3: subtract overflow flag wrong");
        end
        if (op_i[2]) begin
            a_r8_no_exc_logic: assert (!exc_o)
                else $error("R8: exception raised by non-arithmetic op");
        end
        if (op_i == 3'b111) begin
            a_r6_pass_b: assert (res_o == b_i)
                else $error("R6: pass result differs from operand b");
        end
    end
endmodule

bind alu16 alu16_checker #(.W(W)) u_alu16_checker (
    .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .zero_o(zero_o), .exc_o(exc_o)
);

// File: tb/alu16_bench.sv
module alu16_bench;
    logic        clk = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [15:0] a = 16'h0000;
    logic [15:0] b = 16'h0000;
    logic [15:0] res;
    logic        zf, exc;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    alu16 u_alu16 (
        .op_i(op), .a_i(a), .b_i(b),
        .res_o(res), .zero_o(zf), .exc_o(exc)
    );

    function automatic logic [17:0] model(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y);
        int sx, sy, s;
        longint p;
        logic [15:0] r;
        logic e;
        sx = int'($signed(x));
        sy = int'($signed(y));
        e = 1'b0;
        r = 16'h0;
        case (o)
            3'b000: r = 16'h0;
            3'b001: begin s = sx + sy; r = s[15:0]; e = (s > 32767) || (s < -32768); end
            3'b010: begin s = sx - sy; r = s[15:0]; e = (s > 32767) || (s < -32768); end
            3'b011: begin p = longint'(sx) * longint'(sy); r = p[15:0]; e = (p > 32767) || (p < -32768); end
            3'b100: r = x & y;
            3'b101: r = x | y;
            3'b110: r = x ^ y;
            default: r = y;
        endcase
        return {e, (r == 16'h0), r};
    endfunction

    task automatic apply(input string tag, input logic [2:0] o, input logic [15:0] x, input logic [15:0] y);
        logic [17:0] exp;
        @(negedge clk);
        op = o; a = x; b = y;
        #5;
        exp = model(o, x, y);
        checks++;
        if ({exc, zf, res} !== exp) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h: got exc=%b zero=%b res=%h, expected exc=%b zero=%b res=%h",
                     tag, o, x, y, exc, zf, res, exp[17], exp[16], exp[15:0]);
        end
    endtask

    task automatic expect_flag(input string tag, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, want);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #5;
        // R1 reset state: inputs all zero select the no-op
        checks++;
        if (res !== 16'h0 || zf !== 1'b1 || exc !== 1'b0) begin
            errors++;
            $display("FAIL R1 initial: got res=%h zero=%b exc=%b expected 0000 1 0", res, zf, exc);
        end
        apply("R1 nop", 3'b000, 16'h1234, 16'hFFFF);
        apply("R2 add plain", 3'b001, 16'h0003, 16'h0004);
        apply("R2 add pos ovf", 3'b001, 16'h7FFF, 16'h0001);
        apply("R2 add neg ovf", 3'b001, 16'h8000, 16'hFFFF);
        apply("R2 add wrap zero", 3'b001, 16'hFFFF, 16'h0001);
        apply("R3 sub ovf", 3'b010, 16'h8000, 16'h0001);
        apply("R3 sub edge", 3'b010, 16'h0000, 16'h8000);
        apply("R3 sub equal", 3'b010, 16'h5A5A, 16'h5A5A);
        apply("R4 mul small", 3'b011, 16'hFFFD, 16'h0007);
        apply("R4 mul ovf zero", 3'b011, 16'h0100, 16'h0100);
        apply("R4 mul neg one sq", 3'b011, 16'hFFFF, 16'hFFFF);
        apply("R4 mul min neg", 3'b011, 16'h8000, 16'hFFFF);
        apply("R4 mul min fits", 3'b011, 16'h8000, 16'h0001);
        apply("R5 and", 3'b100, 16'hF0F0, 16'h0FF0);
        apply("R5 or", 3'b101, 16'hF000, 16'h000F);
        apply("R5 xor zero", 3'b110, 16'hA5A5, 16'hA5A5);
        apply("R6 pass", 3'b111, 16'h1111, 16'hBEEF);
        apply("R7 pass zero", 3'b111, 16'hFFFF, 16'h0000);
        // R8: exception then a non-flagging operation
        apply("R8 setup ovf", 3'b001, 16'h7FFF, 16'h7FFF);
        expect_flag("R8 exc raised", exc, 1'b1);
        apply("R8 and after ovf", 3'b100, 16'h7FFF, 16'h7FFF);
        expect_flag("R8 exc cleared", exc, 1'b0);
        apply("R8 zero set", 3'b010, 16'h0042, 16'h0042);
        expect_flag("R8 zero raised", zf, 1'b1);
        apply("R8 zero cleared", 3'b101, 16'h0042, 16'h0001);
        expect_flag("R8 zero cleared flag", zf, 1'b0);
        // R2..R7 random sweep over all codes
        for (int i = 0; i < 400; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (i % 5 == 0) rb = ra;
            apply("R7 random", 3'($urandom), ra, rb);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule